// File: doc/BRIEF.md
# K-Means Centroid Averager

This block performs the update half of one k-means pass over a sampled image. Grouping has already tagged every stored match coordinate with the ID of its nearest cluster. The averager then reads the match store once, in address order. Sixteen per-cluster accumulators each add up the row and column of every entry whose tag equals their own ID, and count those entries.

After that sweep the block visits the clusters in ascending ID order. For each one, it feeds the row sum and the column sum, together with the entry count, to two shared sequential dividers. The two floor quotients are written into the centroid register bank. A cluster that received no entries, or whose ID lies outside the active set, keeps the centroid it had before.

A controller starts a pass with a start pulse, a match count and the number of active clusters. A single-cycle completion pulse marks that the bank holds the new values. The match store is read through a simple port with one cycle of read latency.

Top module: `kmeans_averager`

## Requirements
- R1: After reset every centroid reads zero, `done_o` is low and `rd_en_o` is low.
- R2: A pass with match count N > 0 raises `rd_en_o` for exactly N consecutive cycles with `rd_addr_o` stepping 0, 1, ..., N-1. Read data is expected on the cycle after each address.
- R3: Cluster c only sums entries whose 4-bit tag equals c. With the maximum count of 32400 entries at the maximum 11-bit coordinate, no sum overflows.
- R4: For each cluster with ID below the active count and a non-zero entry count, the new row centroid is floor(row sum / count) and the new column centroid is floor(column sum / count).
- R5: A cluster with ID below the active count that received no entries keeps its previous centroid.
- R6: Clusters whose ID is at or above the active count keep their previous centroid. An active count above 16 is treated as 16.
- R7: All sums and counts are cleared when a pass starts, so a pass's result depends only on its own entries.
- R8: `done_o` is high for exactly one cycle per pass, after the last centroid write. A pass with match count 0 still produces this pulse and changes no centroid.
- R9: A start pulse while a pass is in progress is ignored: the running pass is unchanged and only one completion pulse follows.
- R10: Centroid outputs change only on the cycle after a division result is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a pass (accepted only when idle) |
| match_cnt_i | input | 15 | Number of stored matches to sweep |
| active_i | input | 5 | Number of active clusters |
| rd_en_o | output | 1 | Match store read enable |
| rd_addr_o | output | 15 | Match store read address |
| rd_row_i | input | 11 | Row of the addressed match, one cycle after the address |
| rd_col_i | input | 11 | Column of the addressed match, one cycle after the address |
| rd_tag_i | input | 4 | Cluster tag of the addressed match, one cycle after the address |
| cent_row_o | output | 176 | Row centroids, cluster c at bits [11c+10:11c] |
| cent_col_o | output | 176 | Column centroids, cluster c at bits [11c+10:11c] |
| done_o | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The assertions assume the match store answers every read on the following cycle and that `match_cnt_i` never exceeds the store depth. Under those assumptions a quotient can never exceed the coordinate range, and every write targets a cluster with a non-zero count. The bench's memory model always returns registered data one cycle after `rd_en_o`. It only asks for counts up to the 32400-entry maximum, and its coordinates stay within 11 bits, so every mean fits in a centroid field.

// File: rtl/kma_pkg.sv
package kma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWEEP,
    ST_DRAIN,
    ST_PICK,
    ST_WAIT,
    ST_FIN
  } kma_state_e;
endpackage

// File: rtl/kma_accum.sv
module kma_accum #(
  parameter int ID_W    = 4,
  parameter int ID      = 0,
  parameter int COORD_W = 11,
  parameter int CNT_W   = 15,
  parameter int ACC_W   = 26
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               vld_i,
  input  logic [ID_W-1:0]    tag_i,
  input  logic [COORD_W-1:0] row_i,
  input  logic [COORD_W-1:0] col_i,
  output logic [ACC_W-1:0]   sum_row_o,
  output logic [ACC_W-1:0]   sum_col_o,
  output logic [CNT_W-1:0]   cnt_o
);
  logic hit;
  assign hit = vld_i && (tag_i == ID_W'(ID));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_row_o <= '0;
      sum_col_o <= '0;
      cnt_o     <= '0;
    end else if (clr_i) begin
      sum_row_o <= '0;
      sum_col_o <= '0;
      cnt_o     <= '0;
    end else if (hit) begin
      sum_row_o <= sum_row_o + ACC_W'(row_i);
      sum_col_o <= sum_col_o + ACC_W'(col_i);
      cnt_o     <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/kma_divider.sv
module kma_divider #(
  parameter int NUM_W = 26,
  parameter int DEN_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  // One restoring step: shift in the next dividend bit, subtract if it fits.
  function automatic logic [DEN_W:0] try_sub(input logic [DEN_W-1:0] rem,
                                             input logic nbit,
                                             input logic [DEN_W-1:0] den);
    logic [DEN_W:0] wide;
    wide = {rem, nbit};
    if (wide >= {1'b0, den}) return {1'b1, DEN_W'(wide - {1'b0, den})};
    else                     return {1'b0, wide[DEN_W-1:0]};
  endfunction

  logic [DEN_W-1:0]  rem_q, den_q;
  logic [NUM_W-1:0]  quo_q;
  logic [STEP_W-1:0] step_q;
  logic              run_q, done_q;
  logic [DEN_W:0]    nxt;

  assign nxt    = try_sub(rem_q, quo_q[NUM_W-1], den_q);
  assign quo_o  = quo_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      step_q <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        den_q  <= den_i;
        quo_q  <= num_i;
        step_q <= STEP_W'(NUM_W);
        run_q  <= 1'b1;
      end else if (run_q) begin
        rem_q  <= nxt[DEN_W-1:0];
        quo_q  <= {quo_q[NUM_W-2:0], nxt[DEN_W]};
        step_q <= step_q - 1'b1;
        if (step_q == STEP_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kmeans_averager.sv
module kmeans_averager #(
  parameter int N_CLUST   = 16,
  parameter int COORD_W   = 11,
  parameter int MAX_MATCH = 32400
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [$clog2(MAX_MATCH+1)-1:0] match_cnt_i,
  input  logic [$clog2(N_CLUST+1)-1:0]   active_i,
  output logic                       rd_en_o,
  output logic [$clog2(MAX_MATCH)-1:0]   rd_addr_o,
  input  logic [COORD_W-1:0]         rd_row_i,
  input  logic [COORD_W-1:0]         rd_col_i,
  input  logic [$clog2(N_CLUST)-1:0] rd_tag_i,
  output logic [N_CLUST*COORD_W-1:0] cent_row_o,
  output logic [N_CLUST*COORD_W-1:0] cent_col_o,
  output logic                       done_o
);
  import kma_pkg::*;

  localparam int ID_W   = $clog2(N_CLUST);
  localparam int CNT_W  = $clog2(MAX_MATCH + 1);
  localparam int ADDR_W = $clog2(MAX_MATCH);
  localparam int K_W    = $clog2(N_CLUST + 1);
  localparam int ACC_W  = COORD_W + CNT_W;

  kma_state_e        state_q;
  logic [ADDR_W-1:0] idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [K_W-1:0]    act_q, cid_q;
  logic              vld_q;

  logic [ACC_W-1:0]  sum_row [N_CLUST];
  logic [ACC_W-1:0]  sum_col [N_CLUST];
  logic [CNT_W-1:0]  cnt     [N_CLUST];
  logic [COORD_W-1:0] cent_row_q [N_CLUST];
  logic [COORD_W-1:0] cent_col_q [N_CLUST];

  // Named internal events, used by the bound checker.
  logic              busy, accept, clr, div_go, wr_evt, row_done, col_done;
  logic [ID_W-1:0]   sel;
  logic [CNT_W-1:0]  sel_cnt;
  logic [ACC_W-1:0]  quo_row, quo_col;

  assign busy    = (state_q != ST_IDLE);
  assign accept  = start_i && !busy;
  assign clr     = accept;
  assign sel     = cid_q[ID_W-1:0];
  assign sel_cnt = cnt[sel];
  assign div_go  = (state_q == ST_PICK) && (cid_q < act_q) && (sel_cnt != '0);
  assign wr_evt  = (state_q == ST_WAIT) && row_done && col_done;
  assign rd_en_o   = (state_q == ST_SWEEP);
  assign rd_addr_o = idx_q;
  assign done_o    = (state_q == ST_FIN);

  for (genvar g = 0; g < N_CLUST; g++) begin : g_acc
    kma_accum #(
      .ID_W(ID_W), .ID(g), .COORD_W(COORD_W), .CNT_W(CNT_W), .ACC_W(ACC_W)
    ) u_acc (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .vld_i(vld_q),
      .tag_i(rd_tag_i), .row_i(rd_row_i), .col_i(rd_col_i),
      .sum_row_o(sum_row[g]), .sum_col_o(sum_col[g]), .cnt_o(cnt[g])
    );
    assign cent_row_o[g*COORD_W +: COORD_W] = cent_row_q[g];
    assign cent_col_o[g*COORD_W +: COORD_W] = cent_col_q[g];
  end

  kma_divider #(.NUM_W(ACC_W), .DEN_W(CNT_W)) u_div_row (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_go),
    .num_i(sum_row[sel]), .den_i(sel_cnt), .done_o(row_done), .quo_o(quo_row)
  );
  kma_divider #(.NUM_W(ACC_W), .DEN_W(CNT_W)) u_div_col (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_go),
    .num_i(sum_col[sel]), .den_i(sel_cnt), .done_o(col_done), .quo_o(quo_col)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      act_q   <= '0;
      cid_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= rd_en_o;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cnt_q   <= match_cnt_i;
          act_q   <= (active_i > K_W'(N_CLUST)) ? K_W'(N_CLUST) : active_i;
          idx_q   <= '0;
          cid_q   <= '0;
          state_q <= (match_cnt_i == '0) ? ST_PICK : ST_SWEEP;
        end
        ST_SWEEP: begin
          idx_q <= idx_q + 1'b1;
          if (CNT_W'(idx_q) + 1'b1 == cnt_q) state_q <= ST_DRAIN;
        end
        ST_DRAIN: state_q <= ST_PICK;
        ST_PICK: begin
          if (cid_q >= act_q)    state_q <= ST_FIN;
          else if (div_go)       state_q <= ST_WAIT;
          else                   cid_q   <= cid_q + 1'b1;
        end
        ST_WAIT: if (wr_evt) begin
          cid_q   <= cid_q + 1'b1;
          state_q <= ST_PICK;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CLUST; i++) begin
        cent_row_q[i] <= '0;
        cent_col_q[i] <= '0;
      end
    end else if (wr_evt) begin
      cent_row_q[sel] <= quo_row[COORD_W-1:0];
      cent_col_q[sel] <= quo_col[COORD_W-1:0];
    end
  end
endmodule

// File: rtl/kmeans_averager_chk.sv
module kmeans_averager_chk #(
  parameter int N_CLUST = 16,
  parameter int COORD_W = 11,
  parameter int CNT_W   = 15,
  parameter int ADDR_W  = 15,
  parameter int ACC_W   = 26
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       rd_en_o,
  input logic [ADDR_W-1:0]          rd_addr_o,
  input logic [CNT_W-1:0]           cnt_q,
  input logic                       wr_evt,
  input logic [CNT_W-1:0]           sel_cnt,
  input logic [ACC_W-1:0]           quo_row,
  input logic [ACC_W-1:0]           quo_col,
  input logic [N_CLUST*COORD_W-1:0] cent_row_o,
  input logic [N_CLUST*COORD_W-1:0] cent_col_o,
  input logic                       done_o
);
  p_rd_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o && $past(rd_en_o) |-> rd_addr_o == $past(rd_addr_o) + 1'b1);

  p_rd_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> CNT_W'(rd_addr_o) < cnt_q);

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt |-> ((quo_row >> COORD_W) == '0) && ((quo_col >> COORD_W) == '0));

  p_zero_skip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt |-> sel_cnt != '0);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_evt |=> $stable(cent_row_o) && $stable(cent_col_o));
endmodule

bind kmeans_averager kmeans_averager_chk #(
  .N_CLUST(N_CLUST), .COORD_W(COORD_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .ACC_W(ACC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
  .cnt_q(cnt_q), .wr_evt(wr_evt), .sel_cnt(sel_cnt), .quo_row(quo_row),
  .quo_col(quo_col), .cent_row_o(cent_row_o), .cent_col_o(cent_col_o),
  .done_o(done_o)
);

// File: tb/kmeans_averager_tb.sv
module kmeans_averager_tb;
  localparam int NC = 16;
  localparam int CW = 11;
  localparam int FW = NC * CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [14:0]   mcnt = '0;
  logic [4:0]    act = '0;
  logic          rd_en;
  logic [14:0]   rd_addr;
  logic [CW-1:0] rd_row = '0, rd_col = '0;
  logic [3:0]    rd_tag = '0;
  logic [FW-1:0] c_row, c_col;
  logic          done;

  always #4 clk = ~clk;

  kmeans_averager u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .match_cnt_i(mcnt),
    .active_i(act), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_row_i(rd_row), .rd_col_i(rd_col), .rd_tag_i(rd_tag),
    .cent_row_o(c_row), .cent_col_o(c_col), .done_o(done)
  );

  int n_checks = 0, n_fail = 0, n_done = 0, n_reads = 0;
  bit seq_ok = 1'b1;
  int pat_mode = 0;
  logic [CW-1:0] m_row [256];
  logic [CW-1:0] m_col [256];
  logic [3:0]    m_tag [256];
  int exp_row [NC];
  int exp_col [NC];
  logic [2*FW-1:0] sb_q [$];
  string cur_tag = "R1";
  int cur_k = 16;

  function automatic int e_row(int a);
    return (pat_mode == 1) ? 2047 : int'(m_row[a % 256]);
  endfunction
  function automatic int e_col(int a);
    return (pat_mode == 1) ? (2047 - (a % 2)) : int'(m_col[a % 256]);
  endfunction
  function automatic int e_tag(int a);
    return (pat_mode == 1) ? 0 : int'(m_tag[a % 256]);
  endfunction

  // Match store model: one cycle read latency.
  always @(posedge clk) begin
    if (rd_en) begin
      rd_row <= CW'(e_row(int'(rd_addr)));
      rd_col <= CW'(e_col(int'(rd_addr)));
      rd_tag <= 4'(e_tag(int'(rd_addr)));
    end
  end

  task automatic check(input bit ok, input string req, input int actv, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
    end
  endtask

  // Read-address monitor and scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      if (int'(rd_addr) != n_reads) seq_ok = 1'b0;
      n_reads++;
    end
    if (rst_n && done) begin
      n_done++;
      if (sb_q.size() == 0) check(1'b0, "R8", 1, 0);
      else begin
        logic [2*FW-1:0] e;
        e = sb_q.pop_front();
        for (int c = 0; c < NC; c++) begin
          string t;
          t = (c >= cur_k) ? "R6" : cur_tag;
          check(c_row[c*CW +: CW] == e[c*CW +: CW], {t, " row"},
                int'(c_row[c*CW +: CW]), int'(e[c*CW +: CW]));
          check(c_col[c*CW +: CW] == e[FW + c*CW +: CW], {t, " col"},
                int'(c_col[c*CW +: CW]), int'(e[FW + c*CW +: CW]));
        end
      end
    end
  end

  // Driver: compute expected centroids from the requirements, push, start.
  task automatic run_pass(input int n, input int k, input string tag, input bit poke);
    logic [2*FW-1:0] item;
    int keff, d0;
    keff = (k > NC) ? NC : k;
    for (int c = 0; c < keff; c++) begin
      longint sr = 0, sc = 0;
      int cnt = 0;
      for (int a = 0; a < n; a++)
        if (e_tag(a) == c) begin
          sr += e_row(a); sc += e_col(a); cnt++;
        end
      if (cnt != 0) begin
        exp_row[c] = int'(sr / cnt);
        exp_col[c] = int'(sc / cnt);
      end
    end
    for (int c = 0; c < NC; c++) begin
      item[c*CW +: CW]      = CW'(exp_row[c]);
      item[FW + c*CW +: CW] = CW'(exp_col[c]);
    end
    sb_q.push_back(item);
    cur_tag = tag;
    cur_k = keff;
    n_reads = 0;
    seq_ok = 1'b1;
    d0 = n_done;
    @(negedge clk);
    mcnt = 15'(n); act = 5'(k); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      mcnt = 15'd3; act = 5'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (n_done == d0) @(negedge clk);
    repeat (40) @(negedge clk);
    check(seq_ok, "R2 address order", int'(seq_ok), 1);
    check(n_reads == n, "R2 read count", n_reads, n);
    check(n_done == d0 + 1, poke ? "R9 single done" : "R8 single done", n_done - d0, 1);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin exp_row[c] = 0; exp_col[c] = 0; end
    repeat (5) @(negedge clk);
    check(c_row == '0 && c_col == '0, "R1 centroids", int'(c_row[CW-1:0]), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(rd_en == 1'b0, "R1 rd_en", int'(rd_en), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Pass A: all sixteen clusters, scattered tags (R3 tag filter, R4 floor mean).
    for (int a = 0; a < 256; a++) begin
      m_tag[a] = 4'((a * 7) % 16);
      m_row[a] = CW'((a * 37 + 5) % 2048);
      m_col[a] = CW'((a * 101 + 900) % 2048);
    end
    run_pass(64, 16, "R4", 1'b0);

    // Pass B: four active, cluster 2 empty, tags 4 and 5 beyond active (R5, R6, R7).
    for (int a = 0; a < 256; a++) begin
      m_tag[a] = (a % 6 == 2) ? 4'd5 : 4'(a % 6);
      m_row[a] = CW'((a * 13 + 300) % 2048);
      m_col[a] = CW'((a * 29 + 7) % 2048);
    end
    run_pass(40, 4, "R5", 1'b0);

    // Pass C: fewer entries of the same data; stale sums would skew the means (R7).
    run_pass(11, 16, "R7", 1'b0);

    // Pass D: zero matches, every centroid held (R8).
    run_pass(0, 16, "R8", 1'b0);

    // Pass E: active count above the cluster count is clamped (R6).
    run_pass(50, 31, "R6", 1'b0);

    // Pass F: start pulse during a pass is ignored (R9).
    for (int a = 0; a < 256; a++) begin
      m_tag[a] = 4'((a * 3 + 1) % 16);
      m_row[a] = CW'((a * 211) % 2048);
      m_col[a] = CW'((a * 57 + 1000) % 2048);
    end
    run_pass(64, 16, "R9", 1'b1);

    // Pass G: maximum count at maximum coordinate into cluster 0 (R3 no overflow).
    pat_mode = 1;
    run_pass(32400, 1, "R3", 1'b0);
    check(c_row[CW-1:0] == 11'd2047, "R3 row at max", int'(c_row[CW-1:0]), 2047);
    check(c_col[CW-1:0] == 11'd2046, "R4 col floor", int'(c_col[CW-1:0]), 2046);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule